// File: doc/BRIEF.md
# Burst-capable bus master engine

This block turns a one-word command into a complete transfer on a Wishbone master port. A command carries a start address, a byte-select value, a write flag, a burst kind and a beat count. The engine then opens a bus cycle and runs either one classic transfer, a burst that keeps one address for every beat, or a burst whose address advances by one data word per beat. The cycle-type identifier travels in the three most significant bits of the tag output, and every beat follows the rules for its type.

On a write, each beat takes one word from a ready/valid source before its strobe rises. On a read, each acknowledged beat returns its word on a read-data output for one cycle, marked by a valid pulse. When the last beat is acknowledged the engine pulses a success flag. When the slave answers with an error or a retry, the engine closes the cycle on the next clock, drops the remaining beats and pulses an error flag.

Top module: `wb_burst_master`

## Requirements
- R1: While reset is low, CYC and STB are low. After reset, the command port is ready and no read data is flagged valid.
- R2: STB is never high unless CYC is high. CYC rises on the clock that accepts a command, and STB rises no earlier than the clock after that.
- R3: While CYC and STB are high and the slave has given no ACK, ERR or RTY, the next cycle keeps CYC, STB, ADR, SEL, WE, DAT_O and the tag unchanged.
- R4: The three most significant tag bits carry the cycle type: 000 classic, 001 constant-address burst, 010 incrementing burst, 111 end of burst. The lower tag bits are zero. A classic cycle keeps code 000 for as long as CYC stays high.
- R5: Every beat of a burst but the last carries the burst's own code. The last beat carries 111, and 111 stays on the tag until CYC falls.
- R6: After a non-final burst beat is acknowledged, CYC stays high, STB is low for the next cycle and the following beat is then issued. CYC only falls on the clock after a beat that had STB high.
- R7: During a constant-address burst (kind 1), ADR, SEL and WE do not change from the first beat until CYC falls.
- R8: During an incrementing burst (kind 2), each new address equals the previous address plus DATA_W/8, wrapping modulo 2^ADDR_W.
- R9: A command whose kind is 0 or 3, or whose beat count is 0 or 1, is issued as one classic beat with code 000. Its beat count has no further effect.
- R10: If ERR or RTY arrives on any beat, CYC and STB are low on the next clock, the error flag pulses for that one cycle and no further beats are issued.
- R11: When the final beat is acknowledged, CYC and STB are low on the next clock, the success flag pulses for that one cycle and the command port is ready again.
- R12: On an acknowledged read beat, DAT_I is presented on the read-data output with a one-cycle valid pulse on the next clock.
- R13: On a write, the write source is ready only while CYC is high and STB is low. STB rises on the clock after a word is taken, and DAT_O then equals that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Engine idle, command accepted when valid |
| cmdAddr | input | ADDR_W | Start address |
| cmdSel | input | DATA_W/8 | Byte-select value for every beat |
| cmdWrite | input | 1 | 1 for write, 0 for read |
| cmdKind | input | 2 | 0 single, 1 constant-address burst, 2 incrementing burst, 3 single |
| cmdBeats | input | CNT_W | Number of beats |
| wrValid | input | 1 | Write word available |
| wrReady | output | 1 | Write word taken this cycle when valid |
| wrData | input | DATA_W | Write word |
| rdValid | output | 1 | Read word valid pulse |
| rdData | output | DATA_W | Read word |
| doneOk | output | 1 | Transfer completed pulse |
| doneErr | output | 1 | Transfer aborted pulse |
| wbCyc | output | 1 | Bus cycle active |
| wbStb | output | 1 | Beat strobe |
| wbWe | output | 1 | Write enable |
| wbAdr | output | ADDR_W | Address |
| wbSel | output | DATA_W/8 | Byte selects |
| wbDatO | output | DATA_W | Write data to slave |
| wbDatI | input | DATA_W | Read data from slave |
| wbAck | input | 1 | Slave acknowledge |
| wbErr | input | 1 | Slave error |
| wbRty | input | 1 | Slave retry |
| wbTag | output | TAG_W | Tag, cycle type in the top three bits |

## Verification
CYC is due one clock after the command is accepted with STB still low, and the bench checks that on the falling edge right after acceptance. A read strobe follows one clock later, a write strobe one clock after the word is taken, and each beat's address, tag, select and data are compared against a queued expectation on the falling edge where the model slave answers. The read-data pulse, the success or error pulse and the closing of CYC all fall due one clock after the answering edge, so the bench checks them on the next falling edge, where it also checks that CYC stays high with STB low between burst beats.

// File: rtl/wbm_pkg.sv
package wbm_pkg;

  // cycle-type codes placed in the top three tag bits
  typedef enum logic [2:0] {
    CT_CLASSIC = 3'b000,
    CT_CONST   = 3'b001,
    CT_INCR    = 3'b010,
    CT_END     = 3'b111
  } cycType_e;

  // command burst kinds
  localparam logic [1:0] KIND_CONST = 2'd1;
  localparam logic [1:0] KIND_INCR  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // command accepted this cycle
    logic single;    // accepted command runs as one classic beat
    logic takeWord;  // write word taken this cycle
    logic step;      // non-final beat acknowledged
    logic capture;   // read beat acknowledged
    logic busy;      // bus cycle open
    logic lastBeat;  // the pending beat is the final one
  } ctrlStrobe_t;

endpackage

// File: rtl/wbm_ctrl.sv
module wbm_ctrl
  import wbm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic             cmdWrite,
  input  logic [1:0]       cmdKind,
  input  logic [CNT_W-1:0] cmdBeats,
  input  logic             wrValid,
  input  logic             wbAck,
  input  logic             wbErr,
  input  logic             wbRty,
  output logic             cmdReady,
  output logic             wrReady,
  output logic             wbCyc,
  output logic             wbStb,
  output logic             doneOk,
  output logic             doneErr,
  output ctrlStrobe_t      strobe
);

  typedef enum logic {ST_IDLE, ST_BUS} state_e;

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  state_e           state;
  logic             stbReg;
  logic             weReg;
  logic [CNT_W-1:0] remain;
  logic             isSingle;
  logic             fault;
  logic             goodAck;
  logic             accept;

  assign isSingle = !(cmdKind == KIND_CONST || cmdKind == KIND_INCR) || (cmdBeats <= ONE);
  assign fault    = wbErr || wbRty;
  assign goodAck  = wbAck && !fault;
  assign cmdReady = (state == ST_IDLE);
  assign accept   = cmdValid && cmdReady;
  assign wbCyc    = (state == ST_BUS);
  assign wbStb    = stbReg;
  assign wrReady  = (state == ST_BUS) && weReg && !stbReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stbReg  <= 1'b0;
      weReg   <= 1'b0;
      remain  <= '0;
      doneOk  <= 1'b0;
      doneErr <= 1'b0;
    end else begin
      doneOk  <= 1'b0;
      doneErr <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_BUS;
            weReg  <= cmdWrite;
            remain <= isSingle ? ONE : cmdBeats;
          end
        end
        default: begin
          if (!stbReg) begin
            if (!weReg || wrValid) stbReg <= 1'b1;
          end else if (fault) begin
            stbReg  <= 1'b0;
            state   <= ST_IDLE;
            doneErr <= 1'b1;
          end else if (wbAck) begin
            stbReg <= 1'b0;
            if (remain == ONE) begin
              state  <= ST_IDLE;
              doneOk <= 1'b1;
            end else begin
              remain <= remain - ONE;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.load     = accept;
    strobe.single   = isSingle;
    strobe.takeWord = wrReady && wrValid;
    strobe.step     = stbReg && goodAck && (remain != ONE);
    strobe.capture  = stbReg && goodAck && !weReg;
    strobe.busy     = wbCyc;
    strobe.lastBeat = (remain == ONE);
  end

endmodule

// File: rtl/wbm_dpath.sv
module wbm_dpath
  import wbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SEL_W  = DATA_W / 8,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [SEL_W-1:0]  cmdSel,
  input  logic              cmdWrite,
  input  logic [1:0]        cmdKind,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] wbDatI,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [SEL_W-1:0]  wbSel,
  output logic              wbWe,
  output logic [DATA_W-1:0] wbDatO,
  output logic [TAG_W-1:0]  wbTag,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [ADDR_W-1:0] ADR_STEP = ADDR_W'(DATA_W / 8);

  logic [ADDR_W-1:0] adrReg;
  logic [SEL_W-1:0]  selReg;
  logic              weReg;
  logic [DATA_W-1:0] datOReg;
  cycType_e          burstCode;
  cycType_e          beatCode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adrReg    <= '0;
      selReg    <= '0;
      weReg     <= 1'b0;
      datOReg   <= '0;
      burstCode <= CT_CLASSIC;
      rdData    <= '0;
      rdValid   <= 1'b0;
    end else begin
      rdValid <= strobe.capture;
      if (strobe.load) begin
        adrReg <= cmdAddr;
        selReg <= cmdSel;
        weReg  <= cmdWrite;
        if (strobe.single)               burstCode <= CT_CLASSIC;
        else if (cmdKind == KIND_CONST)  burstCode <= CT_CONST;
        else                             burstCode <= CT_INCR;
      end
      if (strobe.step && burstCode == CT_INCR) adrReg <= adrReg + ADR_STEP;
      if (strobe.takeWord) datOReg <= wrData;
      if (strobe.capture)  rdData  <= wbDatI;
    end
  end

  always_comb begin
    if (!strobe.busy)                beatCode = CT_CLASSIC;
    else if (burstCode == CT_CLASSIC) beatCode = CT_CLASSIC;
    else if (strobe.lastBeat)        beatCode = CT_END;
    else                             beatCode = burstCode;
    wbTag = '0;
    wbTag[TAG_W-1 -: 3] = beatCode;
  end

  assign wbAdr  = adrReg;
  assign wbSel  = selReg;
  assign wbWe   = weReg;
  assign wbDatO = datOReg;

endmodule

// File: rtl/wb_burst_master.sv
module wb_burst_master
  import wbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int CNT_W  = 8,
  localparam int SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [SEL_W-1:0]  cmdSel,
  input  logic              cmdWrite,
  input  logic [1:0]        cmdKind,
  input  logic [CNT_W-1:0]  cmdBeats,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [DATA_W-1:0] wrData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              doneOk,
  output logic              doneErr,
  output logic              wbCyc,
  output logic              wbStb,
  output logic              wbWe,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [SEL_W-1:0]  wbSel,
  output logic [DATA_W-1:0] wbDatO,
  input  logic [DATA_W-1:0] wbDatI,
  input  logic              wbAck,
  input  logic              wbErr,
  input  logic              wbRty,
  output logic [TAG_W-1:0]  wbTag
);

  ctrlStrobe_t strobe;

  wbm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdValid (cmdValid),
    .cmdWrite (cmdWrite),
    .cmdKind  (cmdKind),
    .cmdBeats (cmdBeats),
    .wrValid  (wrValid),
    .wbAck    (wbAck),
    .wbErr    (wbErr),
    .wbRty    (wbRty),
    .cmdReady (cmdReady),
    .wrReady  (wrReady),
    .wbCyc    (wbCyc),
    .wbStb    (wbStb),
    .doneOk   (doneOk),
    .doneErr  (doneErr),
    .strobe   (strobe)
  );

  wbm_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .TAG_W  (TAG_W)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .cmdAddr  (cmdAddr),
    .cmdSel   (cmdSel),
    .cmdWrite (cmdWrite),
    .cmdKind  (cmdKind),
    .wrData   (wrData),
    .wbDatI   (wbDatI),
    .wbAdr    (wbAdr),
    .wbSel    (wbSel),
    .wbWe     (wbWe),
    .wbDatO   (wbDatO),
    .wbTag    (wbTag),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

endmodule

// File: rtl/wbm_chk.sv
module wbm_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SEL_W  = DATA_W / 8,
  parameter int TAG_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmdReady,
  input logic              wrValid,
  input logic              wrReady,
  input logic [DATA_W-1:0] wrData,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic              doneOk,
  input logic              doneErr,
  input logic              wbCyc,
  input logic              wbStb,
  input logic              wbWe,
  input logic [ADDR_W-1:0] wbAdr,
  input logic [SEL_W-1:0]  wbSel,
  input logic [DATA_W-1:0] wbDatO,
  input logic [DATA_W-1:0] wbDatI,
  input logic              wbAck,
  input logic              wbErr,
  input logic              wbRty,
  input logic [TAG_W-1:0]  wbTag
);

  localparam logic [ADDR_W-1:0] ADR_STEP = ADDR_W'(DATA_W / 8);

  logic [2:0] code;
  logic       waiting;
  logic       fault;
  logic       goodAck;
  assign code    = wbTag[TAG_W-1 -: 3];
  assign waiting = wbCyc && wbStb && !(wbAck || wbErr || wbRty);
  assign fault   = wbCyc && wbStb && (wbErr || wbRty);
  assign goodAck = wbCyc && wbStb && wbAck && !wbErr && !wbRty;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> !wbCyc && !wbStb);

  // R2
  stb_needs_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n) wbStb |-> wbCyc);

  // R2
  cyc_opens_without_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wbCyc) |-> !wbStb && $past(cmdReady));

  // R3
  hold_while_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |=> wbCyc && wbStb && $stable(wbAdr) && $stable(wbSel) && $stable(wbWe)
                && $stable(wbDatO) && $stable(wbTag));

  // R4
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbCyc |-> (code inside {3'b000, 3'b001, 3'b010, 3'b111}));

  // R4
  classic_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbCyc && $past(wbCyc) && $past(code) == 3'b000 |-> code == 3'b000);

  // R5
  end_code_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbCyc && code == 3'b111 |=> !wbCyc || code == 3'b111);

  // R6
  burst_keeps_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    goodAck && (code == 3'b001 || code == 3'b010) |=> wbCyc && !wbStb);

  // R6
  cyc_falls_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wbCyc) |-> $past(wbStb));

  // R7
  const_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbCyc && $past(wbCyc) && $past(code) == 3'b001
    |-> $stable(wbAdr) && $stable(wbSel) && $stable(wbWe));

  // R8
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbCyc && $past(wbCyc) && $past(code) == 3'b010 && !$stable(wbAdr)
    |-> wbAdr == $past(wbAdr) + ADR_STEP);

  // R10
  fault_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !wbCyc && !wbStb && doneErr && !doneOk);

  // R11
  final_ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    goodAck && (code == 3'b000 || code == 3'b111) |=> !wbCyc && doneOk && cmdReady);

  // R12
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    goodAck && !wbWe |=> rdValid && rdData == $past(wbDatI));

  // R13
  write_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wbStb) && wbWe |-> $past(wrValid && wrReady) && wbDatO == $past(wrData));

  // R13
  wr_ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrReady |-> wbCyc && !wbStb && wbWe);

endmodule

bind wb_burst_master wbm_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .SEL_W  (SEL_W),
  .TAG_W  (TAG_W)
) u_chk (.*);

// File: tb/wb_burst_master_bench.sv
module wb_burst_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 4;
  localparam int CNT_W  = 8;
  localparam int SEL_W  = DATA_W / 8;

  typedef struct {
    logic [ADDR_W-1:0] adr;
    logic [2:0]        code;
    logic              we;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] dat;
    bit                last;
  } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdReady;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [SEL_W-1:0] cmdSel = '0;
  logic cmdWrite = 1'b0;
  logic [1:0] cmdKind = '0;
  logic [CNT_W-1:0] cmdBeats = '0;
  logic wrValid = 1'b0;
  logic wrReady;
  logic [DATA_W-1:0] wrData = '0;
  logic rdValid;
  logic [DATA_W-1:0] rdData;
  logic doneOk, doneErr;
  logic wbCyc, wbStb, wbWe;
  logic [ADDR_W-1:0] wbAdr;
  logic [SEL_W-1:0] wbSel;
  logic [DATA_W-1:0] wbDatO;
  logic [DATA_W-1:0] wbDatI = '0;
  logic wbAck = 1'b0, wbErr = 1'b0, wbRty = 1'b0;
  logic [TAG_W-1:0] wbTag;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wb_burst_master #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .TAG_W (TAG_W), .CNT_W (CNT_W)
  ) u_wb_burst_master (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;

  beat_t beatQ[$];
  logic [DATA_W-1:0] rdQ[$];
  logic [DATA_W-1:0] wq[$];
  int faultBeat = 0;
  bit faultRty = 0;
  int slaveWait = 0;
  int waitLeft = 0;
  int beatNo = 0;
  bit wrStall = 0;
  int tick = 0;
  int pend = 0; // 1 continue, 2 fault, 3 done

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] rdPat(input logic [ADDR_W-1:0] a);
    return {a, ~a};
  endfunction

  // write source
  initial begin
    forever begin
      @(negedge clk);
      tick++;
      wrValid = (wq.size() > 0) && !(wrStall && (tick % 3 == 0));
      wrData  = (wq.size() > 0) ? wq[0] : '0;
      if (wrValid && wrReady) void'(wq.pop_front());
    end
  end

  // slave model and monitor
  initial begin
    forever begin
      @(negedge clk);
      if (pend == 1) check(wbCyc && !wbStb, "R6 gap keeps CYC", {wbCyc, wbStb}, 2'b10);
      if (pend == 2) check(!wbCyc && !wbStb && doneErr && !doneOk, "R10 abort",
                           {wbCyc, wbStb, doneErr, doneOk}, 4'b0010);
      if (pend == 3) check(!wbCyc && doneOk && !doneErr && cmdReady, "R11 done",
                           {wbCyc, doneOk, doneErr, cmdReady}, 4'b0101);
      pend = 0;
      if (rdValid) begin
        if (rdQ.size() == 0) check(0, "R12 unexpected read word", rdData, 0);
        else begin
          logic [DATA_W-1:0] e;
          e = rdQ.pop_front();
          check(rdData == e, "R12 read word", rdData, e);
        end
      end
      wbAck = 0; wbErr = 0; wbRty = 0;
      if (wbCyc && wbStb) begin
        if (waitLeft > 0) waitLeft--;
        else begin
          beatNo++;
          if (beatQ.size() == 0) check(0, "R9 unexpected beat", wbAdr, 0);
          else begin
            beat_t e;
            e = beatQ.pop_front();
            check(wbAdr == e.adr, "R7 R8 beat address", wbAdr, e.adr);
            check(wbTag == {e.code, 1'b0}, "R4 R5 beat tag", wbTag, {e.code, 1'b0});
            check(wbWe == e.we && wbSel == e.sel, "R3 beat WE/SEL", {wbWe, wbSel}, {e.we, e.sel});
            if (e.we) check(wbDatO == e.dat, "R13 write word", wbDatO, e.dat);
            if (beatNo == faultBeat) begin
              if (faultRty) wbRty = 1; else wbErr = 1;
              pend = 2;
            end else begin
              wbAck = 1;
              pend = e.last ? 3 : 1;
            end
          end
          wbDatI = rdPat(wbAdr);
          waitLeft = slaveWait;
        end
      end
    end
  end

  task automatic runCmd(input logic [ADDR_W-1:0] a, input logic [SEL_W-1:0] s, input bit w,
                        input logic [1:0] k, input int n, input int fault, input bit rty,
                        input int wt, input bit stall);
    int effN;
    int guard;
    logic [2:0] bc;
    effN = ((k == 2'd1 || k == 2'd2) && n > 1) ? n : 1;
    bc = (effN == 1) ? 3'b000 : (k == 2'd1 ? 3'b001 : 3'b010);
    for (int i = 0; i < effN; i++) begin
      beat_t b;
      b.adr  = (bc == 3'b010) ? a + ADDR_W'(i * (DATA_W / 8)) : a;
      b.code = (effN == 1) ? 3'b000 : ((i == effN - 1) ? 3'b111 : bc);
      b.we   = w;
      b.sel  = s;
      b.dat  = 32'hA500_0000 + {a, 8'h00} + i;
      b.last = (i == effN - 1);
      if (fault == 0 || i < fault) begin
        beatQ.push_back(b);
        if (w) wq.push_back(b.dat);
        else if (i + 1 != fault) rdQ.push_back(rdPat(b.adr));
      end
    end
    faultBeat = fault; faultRty = rty; slaveWait = wt; waitLeft = wt; beatNo = 0; wrStall = stall;
    @(negedge clk);
    check(cmdReady, "R11 ready before command", cmdReady, 1);
    cmdValid = 1; cmdAddr = a; cmdSel = s; cmdWrite = w; cmdKind = k; cmdBeats = CNT_W'(n);
    @(negedge clk);
    cmdValid = 0;
    check(wbCyc && !wbStb && !cmdReady, "R2 CYC opens first", {wbCyc, wbStb, cmdReady}, 3'b100);
    guard = 0;
    while (wbCyc && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    check(beatQ.size() == 0, "R9 R10 beat count", beatQ.size(), 0);
    check(rdQ.size() == 0, "R12 read words delivered", rdQ.size(), 0);
    check(!wbCyc && !wbStb, "R2 idle after command", {wbCyc, wbStb}, 0);
    beatQ.delete(); rdQ.delete(); wq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!wbCyc && !wbStb, "R1 reset idle", {wbCyc, wbStb}, 0);
    rst_n = 1;
    @(negedge clk);
    check(cmdReady && !rdValid && !doneOk && !doneErr, "R1 after reset",
          {cmdReady, rdValid, doneOk, doneErr}, 4'b1000);
    runCmd(16'h0100, 4'hF, 0, 2'd0, 1, 0, 0, 0, 0);   // single read
    runCmd(16'h0200, 4'h3, 1, 2'd0, 1, 0, 0, 2, 0);   // single write, waits
    runCmd(16'h0300, 4'h3, 0, 2'd1, 4, 0, 0, 1, 0);   // constant read burst R7
    runCmd(16'h0400, 4'hC, 1, 2'd2, 5, 0, 0, 0, 1);   // incrementing write, stalled source R8 R13
    runCmd(16'hFFF8, 4'hF, 0, 2'd2, 3, 0, 0, 0, 0);   // incrementing read with wrap R8
    runCmd(16'h0500, 4'hF, 0, 2'd2, 4, 2, 0, 1, 0);   // error on beat 2 R10
    runCmd(16'h0600, 4'h1, 1, 2'd1, 3, 3, 1, 0, 0);   // retry on last beat R10
    runCmd(16'h0700, 4'hF, 0, 2'd0, 4, 0, 0, 0, 0);   // kind 0 with count 4 R9
    runCmd(16'h0800, 4'hF, 1, 2'd2, 0, 0, 0, 0, 0);   // count 0 R9
    runCmd(16'h0900, 4'h5, 1, 2'd1, 2, 0, 0, 3, 1);   // short constant write R5 R7
    runCmd(16'h0A00, 4'hF, 0, 2'd3, 6, 0, 0, 0, 0);   // kind 3 R9
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule